// File: doc/BRIEF.md
# Programmable-Length Radix-2 FFT Engine

This block computes a complex fast Fourier transform, forward or inverse, for a streaming signal pipeline. Samples arrive as 16-bit real and 16-bit imaginary parts on a valid/ready input. The frame length is chosen per frame as any power of two from 2 up to a compile-time maximum. Each sample can first be scaled by an entry of a loadable weighting table. It is then stored at the bit-reversed address of its position in an in-place working memory.

Once the last sample of a frame is stored, one radix-2 decimation-in-time butterfly is reused for every butterfly of every stage, at one butterfly per clock. Twiddle factors come from an internal quarter-free half-circle table. The inverse transform uses the conjugated twiddles and applies no 1/N factor. Results leave in natural bin order on a valid/ready output. A programmable right shift with rounding is applied to each result, and a last-beat flag marks the final bin of the frame.

Top module: `fft_engine`

## Requirements
- R1: After reset the engine is idle: `s_ready` is 1, and `m_valid` and `m_last` are 0.
- R2: With `cfg_inverse`=0, output beat k of a frame of N samples x[n] equals the sum over n of x[n]·e^(-j2πkn/N), delivered in natural order k = 0..N-1, within the error of 16-bit rounding at each stage.
- R3: With `cfg_inverse`=1, output beat k equals the sum over n of x[n]·e^(+j2πkn/N), with no division by N.
- R4: `cfg_len_log2` = L (1..MAX_LOG2) makes a frame of N = 2^L accepted samples and N output beats, and `m_last` is 1 on the Nth output beat only.
- R5: With `cfg_win_en`=1, each component of input sample n is replaced by (x·w[n] + 2^14) >>> 15 before the transform, where w[n] is the signed Q1.15 table entry at address n.
- R6: Every table entry resets to 32767. A write (`win_we`=1) takes effect only while the engine is idle between frames; writes made while a frame is being loaded, computed or output are dropped.
- R7: Each output component equals (v + 2^(s-1)) >>> s for s = `cfg_shift` > 0, and equals v for s = 0, clamped to the 16-bit range.
- R8: The length, direction, shift and window enable are sampled with the first accepted sample of a frame; changing them later in that frame has no effect on its results.
- R9: Butterfly results that exceed the 16-bit range clamp to 32767 or -32768 and do not wrap.
- R10: No sample is accepted while results are pending (`s_ready` is 0 whenever `m_valid` is 1), and while `m_valid` is 1 with `m_ready` 0, `m_valid`, `m_re` and `m_im` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_len_log2 | input | $clog2(MAX_LOG2+1) | Frame length exponent L, N = 2^L |
| cfg_inverse | input | 1 | 1 selects the inverse transform |
| cfg_shift | input | 4 | Output right-shift amount |
| cfg_win_en | input | 1 | 1 applies the weighting table to inputs |
| win_we | input | 1 | Weighting table write strobe |
| win_addr | input | MAX_LOG2 | Weighting table write address |
| win_data | input | 16 | Weighting coefficient, signed Q1.15 |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Engine accepts an input sample |
| s_re | input | 16 | Input real part, signed |
| s_im | input | 16 | Input imaginary part, signed |
| m_valid | output | 1 | Output bin valid |
| m_ready | input | 1 | Downstream accepts the output bin |
| m_re | output | 16 | Output real part, signed |
| m_im | output | 16 | Output imaginary part, signed |
| m_last | output | 1 | Marks the final bin of the frame |

## Verification
The assertions assume the configuration pins carry a length exponent within 1..MAX_LOG2 at the first sample of a frame, and that the downstream consumer eventually raises `m_ready` so the output phase ends. The stimulus always programs a legal length before a frame starts, then scrambles every configuration pin after the first sample to probe R8. It stalls the output with random `m_ready` gaps. Random sample amplitudes are limited to about 16000/N per component so that a correct transform never reaches saturation, except in the one directed frame built to exercise R9.

// File: rtl/fft_pkg.sv
package fft_pkg;

    typedef struct packed {
        logic signed [15:0] re;
        logic signed [15:0] im;
    } cplx_t;

    typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_CALC, ST_OUT} fft_state_t;

    // clamp a wide signed value into 16 bits
    function automatic logic signed [15:0] sat16(input logic signed [31:0] v);
        if (v > 32'sd32767)       return 16'sh7fff;
        else if (v < -32'sd32768) return 16'sh8000;
        else                      return v[15:0];
    endfunction

    // round-half-up removal of 15 fraction bits
    function automatic logic signed [31:0] q15_round(input logic signed [33:0] p);
        logic signed [33:0] t;
        t = p + 34'sd16384;
        return 32'(t >>> 15);
    endfunction

    // programmable output shift with rounding
    function automatic logic signed [15:0] gain_shift(input logic signed [15:0] v,
                                                      input logic [3:0] sh);
        logic signed [31:0] t;
        if (sh == 4'd0) return v;
        t = 32'(v) + (32'sd1 <<< (sh - 4'd1));
        return sat16(t >>> sh);
    endfunction

    // twiddle entry k of a table of max_n points, Q1.15, from a series expansion
    function automatic logic signed [15:0] tw_value(input int k, input int max_n,
                                                    input bit want_sin);
        real pi, a, c, s, ct, st, v;
        bit  flip;
        pi   = 3.14159265358979323846;
        a    = 2.0 * pi * k / max_n;
        flip = 1'b0;
        if (a > pi / 2.0) begin
            a    = pi - a;
            flip = 1'b1;
        end
        c  = 1.0;
        s  = a;
        ct = 1.0;
        st = a;
        for (int i = 1; i <= 12; i++) begin
            ct = -ct * a * a / ((2.0 * i - 1.0) * (2.0 * i));
            st = -st * a * a / ((2.0 * i) * (2.0 * i + 1.0));
            c  = c + ct;
            s  = s + st;
        end
        if (flip) c = -c;
        v = want_sin ? s * 32767.0 : c * 32767.0;
        v = (v >= 0.0) ? v + 0.5 : v - 0.5;
        return 16'($rtoi(v));
    endfunction

endpackage

// File: rtl/fft_twiddle_rom.sv
module fft_twiddle_rom
    import fft_pkg::*;
#(
    parameter int MAX_LOG2 = 8
) (
    input  logic [MAX_LOG2-2:0] idx,
    output logic signed [15:0]  w_cos,
    output logic signed [15:0]  w_sin
);
    localparam int MAX_N = 1 << MAX_LOG2;
    localparam int HALF  = MAX_N / 2;

    logic signed [15:0] cos_tab [HALF];
    logic signed [15:0] sin_tab [HALF];

    for (genvar k = 0; k < HALF; k++) begin : g_tw
        localparam logic signed [15:0] C_VAL = tw_value(k, MAX_N, 1'b0);
        localparam logic signed [15:0] S_VAL = tw_value(k, MAX_N, 1'b1);
        assign cos_tab[k] = C_VAL;
        assign sin_tab[k] = S_VAL;
    end

    assign w_cos = cos_tab[idx];
    assign w_sin = sin_tab[idx];
endmodule

// File: rtl/fft_butterfly.sv
module fft_butterfly
    import fft_pkg::*;
(
    input  cplx_t              a,
    input  cplx_t              b,
    input  logic signed [15:0] w_cos,
    input  logic signed [15:0] w_sin,
    input  logic               inv,
    output cplx_t              x,
    output cplx_t              y
);
    logic signed [15:0] wr, wi;
    logic signed [33:0] pr, pi;
    logic signed [31:0] tr, ti;

    always_comb begin
        // forward uses cos - j sin, inverse the conjugate
        wr = w_cos;
        wi = inv ? w_sin : -w_sin;
        pr = 34'(b.re) * 34'(wr) - 34'(b.im) * 34'(wi);
        pi = 34'(b.re) * 34'(wi) + 34'(b.im) * 34'(wr);
        tr = q15_round(pr);
        ti = q15_round(pi);
        x.re = sat16(32'(a.re) + tr);
        x.im = sat16(32'(a.im) + ti);
        y.re = sat16(32'(a.re) - tr);
        y.im = sat16(32'(a.im) - ti);
    end
endmodule

// File: rtl/fft_window_ram.sv
module fft_window_ram #(
    parameter int MAX_LOG2 = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_allow,
    input  logic                we,
    input  logic [MAX_LOG2-1:0] waddr,
    input  logic [15:0]         wdata,
    input  logic [MAX_LOG2-1:0] raddr,
    output logic signed [15:0]  rdata
);
    localparam int DEPTH = 1 << MAX_LOG2;

    logic [DEPTH-1:0][15:0] ram_d, ram_q;

    always_comb begin
        ram_d = ram_q;
        if (we && wr_allow) ram_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ram_q <= {DEPTH{16'h7fff}};
        else        ram_q <= ram_d;
    end

    assign rdata = ram_q[raddr];

    // table frozen outside the idle window
    p_win_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_allow |=> $stable(ram_q));
endmodule

// File: rtl/fft_engine.sv
module fft_engine
    import fft_pkg::*;
#(
    parameter int MAX_LOG2 = 8,
    localparam int LW = $clog2(MAX_LOG2 + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LW-1:0]       cfg_len_log2,
    input  logic                cfg_inverse,
    input  logic [3:0]          cfg_shift,
    input  logic                cfg_win_en,
    input  logic                win_we,
    input  logic [MAX_LOG2-1:0] win_addr,
    input  logic [15:0]         win_data,
    input  logic                s_valid,
    output logic                s_ready,
    input  logic signed [15:0]  s_re,
    input  logic signed [15:0]  s_im,
    output logic                m_valid,
    input  logic                m_ready,
    output logic signed [15:0]  m_re,
    output logic signed [15:0]  m_im,
    output logic                m_last
);
    localparam int MAXL  = MAX_LOG2;
    localparam int MAX_N = 1 << MAXL;
    localparam int SW    = $clog2(MAXL);

    typedef struct packed {
        fft_state_t     st;
        logic [MAXL-1:0] cnt;
        logic [LW-1:0]   len;
        logic            inv;
        logic [3:0]      shift;
        logic            win_en;
        logic [SW-1:0]   stage;
        logic [MAXL-1:0] bf;
    } ctl_t;

    ctl_t  r_d, r_q;
    cplx_t mem_d [MAX_N];
    cplx_t mem_q [MAX_N];

    logic [LW-1:0]       len_in, eff_len;
    logic                eff_win;
    logic [MAXL:0]       n_cur, half;
    logic [MAXL-1:0]     rev_full, ld_addr;
    logic [MAXL-1:0]     h, pos, grp, top, bot;
    logic [MAXL-2:0]     tw_idx;
    logic signed [15:0]  w_cos, w_sin, win_rdata;
    cplx_t               smp, bx, by;
    logic                cnt_last, bf_last, stage_last;

    // legal range clamp of the requested length
    always_comb begin
        if (cfg_len_log2 == '0)               len_in = LW'(1);
        else if (cfg_len_log2 > LW'(MAXL))    len_in = LW'(MAXL);
        else                                  len_in = cfg_len_log2;
    end

    // butterfly operand addressing for the current stage
    always_comb begin
        h      = MAXL'(1) << r_q.stage;
        pos    = r_q.bf & (h - MAXL'(1));
        grp    = r_q.bf >> r_q.stage;
        top    = MAXL'(grp << (int'(r_q.stage) + 1)) | pos;
        bot    = top | h;
        tw_idx = (MAXL-1)'(pos << (MAXL - 1 - int'(r_q.stage)));
    end

    fft_twiddle_rom #(.MAX_LOG2(MAXL)) i_rom (
        .idx  (tw_idx),
        .w_cos(w_cos),
        .w_sin(w_sin)
    );

    fft_butterfly i_bfly (
        .a    (mem_q[top]),
        .b    (mem_q[bot]),
        .w_cos(w_cos),
        .w_sin(w_sin),
        .inv  (r_q.inv),
        .x    (bx),
        .y    (by)
    );

    fft_window_ram #(.MAX_LOG2(MAXL)) i_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_allow(r_q.st == ST_IDLE),
        .we      (win_we),
        .waddr   (win_addr),
        .wdata   (win_data),
        .raddr   (r_q.cnt),
        .rdata   (win_rdata)
    );

    always_comb begin
        r_d   = r_q;
        mem_d = mem_q;

        s_ready = 1'b0;
        m_valid = 1'b0;
        m_last  = 1'b0;
        m_re    = '0;
        m_im    = '0;

        eff_len = (r_q.st == ST_IDLE) ? len_in : r_q.len;
        eff_win = (r_q.st == ST_IDLE) ? cfg_win_en : r_q.win_en;
        n_cur   = (MAXL+1)'(1) << eff_len;
        half    = n_cur >> 1;

        for (int i = 0; i < MAXL; i++) rev_full[MAXL-1-i] = r_q.cnt[i];
        ld_addr = rev_full >> (MAXL - int'(eff_len));

        cnt_last   = ({1'b0, r_q.cnt} == n_cur - (MAXL+1)'(1));
        bf_last    = ({1'b0, r_q.bf} == half - (MAXL+1)'(1));
        stage_last = (int'(r_q.stage) == int'(r_q.len) - 1);

        smp.re = s_re;
        smp.im = s_im;
        if (eff_win) begin
            smp.re = sat16(q15_round(34'(s_re) * 34'(win_rdata)));
            smp.im = sat16(q15_round(34'(s_im) * 34'(win_rdata)));
        end

        case (r_q.st)
            ST_IDLE: begin
                s_ready = 1'b1;
                if (s_valid) begin
                    r_d.len      = len_in;
                    r_d.inv      = cfg_inverse;
                    r_d.shift    = cfg_shift;
                    r_d.win_en   = cfg_win_en;
                    mem_d[ld_addr] = smp;
                    r_d.cnt      = MAXL'(1);
                    r_d.st       = ST_LOAD;
                end
            end
            ST_LOAD: begin
                s_ready = 1'b1;
                if (s_valid) begin
                    mem_d[ld_addr] = smp;
                    if (cnt_last) begin
                        r_d.st    = ST_CALC;
                        r_d.cnt   = '0;
                        r_d.stage = '0;
                        r_d.bf    = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + MAXL'(1);
                    end
                end
            end
            ST_CALC: begin
                mem_d[top] = bx;
                mem_d[bot] = by;
                if (bf_last) begin
                    r_d.bf = '0;
                    if (stage_last) r_d.st    = ST_OUT;
                    else            r_d.stage = r_q.stage + SW'(1);
                end else begin
                    r_d.bf = r_q.bf + MAXL'(1);
                end
            end
            default: begin
                m_valid = 1'b1;
                m_last  = cnt_last;
                m_re    = gain_shift(mem_q[r_q.cnt].re, r_q.shift);
                m_im    = gain_shift(mem_q[r_q.cnt].im, r_q.shift);
                if (m_ready) begin
                    if (cnt_last) begin
                        r_d.st  = ST_IDLE;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + MAXL'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q   <= '0;
            mem_q <= '{default: '0};
        end else begin
            r_q   <= r_d;
            mem_q <= mem_d;
        end
    end

    // output held under backpressure
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && !m_ready |=> m_valid && $stable(m_re) && $stable(m_im));

    // input and output phases never overlap
    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_ready && m_valid));

    // frame settings frozen once a frame has started
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE) |=> $stable(r_q.len) && $stable(r_q.inv)
                                && $stable(r_q.shift) && $stable(r_q.win_en));

    // the last beat closes the frame and reopens the input
    p_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && m_ready && m_last |=> !m_valid && s_ready);

    // butterfly pair lies inside the active frame
    p_bfly_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CALC) |-> (top < bot) && ({1'b0, bot} < n_cur));
endmodule

// File: tb/test_fft_engine.sv
module test_fft_engine;
    localparam int MAXL = 8;
    localparam int MAXN = 1 << MAXL;
    localparam int LW   = $clog2(MAXL + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [LW-1:0]     cfg_len_log2 = LW'(1);
    logic              cfg_inverse = 1'b0;
    logic [3:0]        cfg_shift = '0;
    logic              cfg_win_en = 1'b0;
    logic              win_we = 1'b0;
    logic [MAXL-1:0]   win_addr = '0;
    logic [15:0]       win_data = '0;
    logic              s_valid = 1'b0;
    logic              s_ready;
    logic signed [15:0] s_re = '0, s_im = '0;
    logic              m_valid;
    logic              m_ready = 1'b0;
    logic signed [15:0] m_re, m_im;
    logic              m_last;

    always #2 clk = ~clk;

    fft_engine #(.MAX_LOG2(MAXL)) i_fft_engine (.*);

    int n_chk = 0, n_bad = 0;
    int xr[MAXN], xi[MAXN], win[MAXN], orr[MAXN], oi[MAXN];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int clamp16(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int rnd_real(input real v);
        return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    endfunction

    task automatic fill_random(input int n);
        int a;
        a = 16000 / n;
        for (int i = 0; i < n; i++) begin
            xr[i] = int'($urandom % (2 * a + 1)) - a;
            xi[i] = int'($urandom % (2 * a + 1)) - a;
        end
    endtask

    task automatic fill_zero();
        for (int i = 0; i < MAXN; i++) begin xr[i] = 0; xi[i] = 0; end
    endtask

    task automatic load_window();
        for (int k = 0; k < MAXN; k++) begin
            @(negedge clk);
            win[k]   = int'($urandom % 32768);
            win_we   = 1'b1;
            win_addr = MAXL'(k);
            win_data = 16'(win[k]);
        end
        @(negedge clk);
        win_we = 1'b0;
    endtask

    task automatic run_frame(input int L, input bit inv, input int sh, input bit wen,
                             input bit poke, input string req);
        int n, idx, tol, er, ei, hr, hi;
        bit held;
        real sr, si, ang, a, b, sgn;
        n = 1 << L;
        @(negedge clk);
        while (!s_ready) @(negedge clk);
        cfg_len_log2 = LW'(L);
        cfg_inverse  = inv;
        cfg_shift    = 4'(sh);
        cfg_win_en   = wen;
        for (int i = 0; i < n; i++) begin
            if (i == 1) begin // R8: scramble settings after the first sample
                cfg_len_log2 = LW'($urandom % (MAXL + 1));
                cfg_inverse  = ~inv;
                cfg_shift    = 4'($urandom);
                cfg_win_en   = ~wen;
            end
            s_valid = 1'b1;
            s_re    = 16'(xr[i]);
            s_im    = 16'(xi[i]);
            @(negedge clk);
        end
        s_valid = 1'b0;
        if (poke) begin // R6: writes while busy must be dropped
            for (int k = 0; k < 4; k++) begin
                win_we = 1'b1; win_addr = MAXL'(k); win_data = 16'h0000;
                @(negedge clk);
            end
            win_we = 1'b0;
        end
        idx = 0; held = 1'b0; hr = 0; hi = 0;
        while (idx < n) begin
            m_ready = ($urandom % 4) != 0;
            #1;
            if (held) begin
                chk(m_valid && int'(m_re) == hr && int'(m_im) == hi, "R10",
                    "held output", int'(m_re), hr);
            end
            held = 1'b0;
            if (m_valid) begin
                if (s_ready) chk(1'b0, "R10", "s_ready with m_valid", 1, 0);
                if (m_ready) begin
                    orr[idx] = int'(m_re);
                    oi[idx]  = int'(m_im);
                    chk(m_last == (idx == n - 1), "R4", "m_last", int'(m_last),
                        int'(idx == n - 1));
                    idx++;
                end else begin
                    held = 1'b1; hr = int'(m_re); hi = int'(m_im);
                end
            end
            @(negedge clk);
        end
        m_ready = 1'b0;
        #1;
        chk(!m_valid && s_ready, "R4", "frame end after N beats", int'(m_valid), 0);
        // expected spectrum from the definition
        sgn = inv ? 1.0 : -1.0;
        tol = ((n / 2 + 4) >> sh) + 2;
        for (int k = 0; k < n; k++) begin
            sr = 0.0; si = 0.0;
            for (int i = 0; i < n; i++) begin
                a = wen ? real'((xr[i] * win[i] + 16384) >>> 15) : real'(xr[i]);
                b = wen ? real'((xi[i] * win[i] + 16384) >>> 15) : real'(xi[i]);
                ang = sgn * 2.0 * 3.14159265358979 * k * i / n;
                sr += a * $cos(ang) - b * $sin(ang);
                si += a * $sin(ang) + b * $cos(ang);
            end
            er = clamp16(rnd_real(sr / real'(1 << sh)));
            ei = clamp16(rnd_real(si / real'(1 << sh)));
            chk((orr[k] - er) <= tol && (er - orr[k]) <= tol, req, "bin re", orr[k], er);
            chk((oi[k] - ei) <= tol && (ei - oi[k]) <= tol, req, "bin im", oi[k], ei);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int k = 0; k < MAXN; k++) win[k] = 32767;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(s_ready == 1'b1, "R1", "s_ready", int'(s_ready), 1);
        chk(m_valid == 1'b0 && m_last == 1'b0, "R1", "m_valid", int'(m_valid), 0);
        rst_n = 1'b1;

        // R9: two large equal samples, bin 0 clamps
        fill_zero(); xr[0] = 30000; xr[1] = 30000;
        run_frame(1, 1'b0, 0, 1'b0, 1'b0, "R9");
        chk(orr[0] == 32767, "R9", "saturated bin", orr[0], 32767);

        // R7: impulse of 1000 with shift 3 gives 125 in every bin
        fill_zero(); xr[0] = 1000;
        run_frame(3, 1'b0, 3, 1'b0, 1'b0, "R7");
        for (int k = 0; k < 8; k++)
            chk(orr[k] == 125 && oi[k] == 0, "R7", "shifted impulse", orr[k], 125);

        // R3: shifted impulse rotates the opposite way in inverse mode
        fill_zero(); xr[1] = 1000;
        run_frame(3, 1'b1, 0, 1'b0, 1'b0, "R3");
        chk(oi[2] > 900, "R3", "bin 2 imaginary sign", oi[2], 1000);
        fill_random(16);
        run_frame(4, 1'b1, 1, 1'b0, 1'b0, "R3");

        // R6: reset table is unity-like
        fill_random(16);
        run_frame(4, 1'b0, 0, 1'b1, 1'b0, "R6");

        // R5: loaded table, with writes attempted while busy
        load_window();
        fill_random(32);
        run_frame(5, 1'b0, 1, 1'b1, 1'b1, "R5");
        fill_random(32);
        run_frame(5, 1'b0, 0, 1'b1, 1'b1, "R6");

        // R2 / R4 / R8: random frames across lengths and settings
        for (int f = 0; f < 10; f++) begin
            int L;
            L = (f < MAXL) ? f + 1 : 1 + int'($urandom % MAXL);
            fill_random(1 << L);
            run_frame(L, 1'(($urandom % 3) == 0), int'($urandom % 3),
                      1'($urandom % 2), 1'b0, (f % 2) ? "R8" : "R2");
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule